// File: doc/BRIEF.md
# ECC Error Status and Log Recorder

This block sits beside a DRAM controller's ECC checkers and keeps the evidence of memory errors until software collects it. Each channel's checker reports a correctable strobe, an uncorrectable strobe, and the rank, bank, row, column and syndrome of the failing access. The block folds these reports into a small status word of sticky error flags and into one 64-bit error record per channel. A level output is high while any error flag is set, so an interrupt controller can use it directly.

Software reads the status word, the two halves of each channel record and a derived word of system-wide rank indices through a simple register port. It clears the status flags by writing ones. The record policy preserves the most useful evidence. The first correctable error is kept. An uncorrectable error replaces a correctable record. An uncorrectable record is frozen until software clears the status. A mode input turns the block into a single-channel recorder that ignores the second checker.

The checker event inputs are plain strobes with no ready signal and are never back-pressured. An event is taken in the cycle its strobe is high. Register reads are combinational. Writes take effect at the next clock edge.

Top module: `ecc_err_recorder`

## Requirements
- R1: A correctable event on an active channel sets status bit 0, and an uncorrectable event sets status bit 1. Status bits 31:2 always read as zero.
- R2: Writing to address 0 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. An event in the same cycle as the write wins, and its bit stays set.
- R3: A channel record packs the following fields. Column is in bits 63:48. Row is in 47:32. Bank is in 31:29. Rank is in 28:27. Syndrome is in 23:16. The uncorrectable flag is bit 1 and the correctable flag is bit 0. All other bits are zero. The low half of channel 0's record reads at address 2 and the high half at address 3. Channel 1 uses addresses 4 and 5.
- R4: An uncorrectable event replaces a held correctable record, which leaves flags 2'b10. Status bit 0 stays set.
- R5: While a record holds the uncorrectable flag, later events of either kind leave the record unchanged.
- R6: A correctable event is logged only when both record flags are zero, so the first correctable record is kept.
- R7: When single_chan is 1, channel 1 events change neither the status word nor channel 1's record.
- R8: A status write that leaves both status bits zero clears bits 1:0 of every record and keeps the address and syndrome fields.
- R9: A correctable and an uncorrectable event on one channel in the same cycle set both status bits and log the record with flags 2'b10.
- R10: err_irq is high exactly while status bit 0 or bit 1 is set.
- R11: Address 1 reads the global rank of each channel's record. The global rank is the logged rank plus 4 times the channel number. Channel c's value is placed in bits 4c+2:4c.
- R12: After reset the status word, both records and err_irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| single_chan | input | 1 | 1 = only channel 0 is recorded |
| ev_ce | input | 2 | Correctable error strobe, one per channel |
| ev_ue | input | 2 | Uncorrectable error strobe, one per channel |
| ev_rank | input | 4 | Rank of the failing access, 2 bits per channel |
| ev_bank | input | 6 | Bank, 3 bits per channel |
| ev_row | input | 32 | Row address, 16 bits per channel |
| ev_col | input | 32 | Column address, 16 bits per channel |
| ev_synd | input | 16 | ECC syndrome, 8 bits per channel |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| err_irq | output | 1 | High while any error flag is set |

## Verification
The bench builds the block with its default values of two channels and four ranks per channel. These defaults bring channel 1's record, its global rank offset of 4 and the single-channel mode within reach. Directed sequences on channel 0 walk the record through the empty, correctable, uncorrectable and cleared states. These sequences include same-cycle correctable and uncorrectable strobes, and a clear that collides with a new event.

// File: rtl/ecc_rec_pkg.sv
package ecc_rec_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYND_W = 8;
  localparam int LOG_W  = 64;
  localparam int RANK_LSB = 27;
  localparam logic [1:0] FLG_CE = 2'b01;
  localparam logic [1:0] FLG_UE = 2'b10;

  function automatic logic [LOG_W-1:0] pack_record(
    input logic [COL_W-1:0]  col,
    input logic [ROW_W-1:0]  row,
    input logic [BANK_W-1:0] bank,
    input logic [RANK_W-1:0] rank,
    input logic [SYND_W-1:0] synd,
    input logic [1:0]        flags);
    pack_record = {col, row, bank, rank, 3'b000, synd, 14'd0, flags};
  endfunction
endpackage

// File: rtl/ecc_status_reg.sv
module ecc_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic [1:0] w1c,
  input  logic       set_ce,
  input  logic       set_ue,
  output logic [1:0] st_q,
  output logic       clr_flags
);
  logic [1:0] st_n;

  always_comb begin
    st_n = st_q & ~(wr_stat ? w1c : 2'b00);
    st_n = st_n | {set_ue, set_ce};
  end

  assign clr_flags = wr_stat && (st_n == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 2'b00;
    else        st_q <= st_n;
  end

  p_ue_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_ue |=> st_q[1]);
  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && w1c[0] && !set_ce) |=> !st_q[0]);
  p_w0_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[0] && !(wr_stat && w1c[0])) |=> st_q[0]);
endmodule

// File: rtl/ecc_chan_log.sv
module ecc_chan_log
  import ecc_rec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ce,
  input  logic              ue,
  input  logic [RANK_W-1:0] rank,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [SYND_W-1:0] synd,
  input  logic              clr_flags,
  output logic [LOG_W-1:0]  log_q,
  output logic              ce_evt,
  output logic              ue_evt
);
  logic take_ue, take_ce;

  assign ue_evt  = en & ue;
  assign ce_evt  = en & ce;
  assign take_ue = ue_evt & ~log_q[1];
  assign take_ce = ce_evt & ~ue_evt & (log_q[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         log_q <= '0;
    else if (take_ue)   log_q <= pack_record(col, row, bank, rank, synd, FLG_UE);
    else if (take_ce)   log_q <= pack_record(col, row, bank, rank, synd, FLG_CE);
    else if (clr_flags) log_q[1:0] <= 2'b00;
  end

  p_ue_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q[1] && !clr_flags) |=> $stable(log_q));
  p_first_ce_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((log_q[1:0] == FLG_CE) && !ue_evt && !clr_flags) |=> $stable(log_q));
  p_idle_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_flags) |=> $stable(log_q));
endmodule

// File: rtl/ecc_err_recorder.sv
module ecc_err_recorder
  import ecc_rec_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int RPC    = 4,
  parameter int ADDR_W = 3,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   single_chan,
  input  logic [NCH-1:0]         ev_ce,
  input  logic [NCH-1:0]         ev_ue,
  input  logic [NCH*RANK_W-1:0]  ev_rank,
  input  logic [NCH*BANK_W-1:0]  ev_bank,
  input  logic [NCH*ROW_W-1:0]   ev_row,
  input  logic [NCH*COL_W-1:0]   ev_col,
  input  logic [NCH*SYND_W-1:0]  ev_synd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic                   err_irq
);
  localparam int GR_W     = $clog2(NCH * RPC);
  localparam int LOG_BASE = 2;

  logic [LOG_W-1:0] log_q [NCH];
  logic [NCH-1:0]   ce_evt, ue_evt;
  logic [1:0]       st_q;
  logic             clr_flags;
  logic [DW-1:0]    rank_word;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic en;
    assign en = (c == 0) ? 1'b1 : ~single_chan;
    ecc_chan_log u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .ce        (ev_ce[c]),
      .ue        (ev_ue[c]),
      .rank      (ev_rank[c*RANK_W +: RANK_W]),
      .bank      (ev_bank[c*BANK_W +: BANK_W]),
      .row       (ev_row[c*ROW_W +: ROW_W]),
      .col       (ev_col[c*COL_W +: COL_W]),
      .synd      (ev_synd[c*SYND_W +: SYND_W]),
      .clr_flags (clr_flags),
      .log_q     (log_q[c]),
      .ce_evt    (ce_evt[c]),
      .ue_evt    (ue_evt[c])
    );
  end

  ecc_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stat   (reg_wr && (reg_addr == '0)),
    .w1c       (reg_wdata[1:0]),
    .set_ce    (|ce_evt),
    .set_ue    (|ue_evt),
    .st_q      (st_q),
    .clr_flags (clr_flags)
  );

  always_comb begin
    rank_word = '0;
    for (int c = 0; c < NCH; c++)
      rank_word[c*4 +: GR_W] = GR_W'(c * RPC) + GR_W'(log_q[c][RANK_LSB +: RANK_W]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(0))      reg_rdata = {{(DW-2){1'b0}}, st_q};
    else if (reg_addr == ADDR_W'(1)) reg_rdata = rank_word;
    else begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == ADDR_W'(LOG_BASE + 2*c))     reg_rdata = log_q[c][DW-1:0];
        if (reg_addr == ADDR_W'(LOG_BASE + 2*c + 1)) reg_rdata = log_q[c][LOG_W-1:DW];
      end
    end
  end

  assign err_irq = |st_q;

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt[0]) |=> err_irq);
endmodule

// File: tb/tb_ecc_err_recorder.sv
`timescale 1ns/1ps
module tb_ecc_err_recorder;
  logic clk = 0, rst_n = 0, single_chan = 0;
  logic [1:0] ev_ce = 0, ev_ue = 0;
  logic [3:0] ev_rank = 0;
  logic [5:0] ev_bank = 0;
  logic [31:0] ev_row = 0, ev_col = 0;
  logic [15:0] ev_synd = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic err_irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ecc_err_recorder dut (.*);

  function automatic logic [63:0] rec(input logic [15:0] col, row, input logic [2:0] bank,
                                      input logic [1:0] rank, input logic [7:0] synd, input logic [1:0] f);
    return {col, row, bank, rank, 3'b000, synd, 14'd0, f};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic rd_log(input int ch, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'(2 + 2*ch), lo); rd(3'(3 + 2*ch), hi); v = {hi, lo};
  endtask

  task automatic post(input int ch, input logic ce, ue, input logic [1:0] rank, input logic [2:0] bank,
                      input logic [15:0] row, col, input logic [7:0] synd, input logic wr = 0,
                      input logic [1:0] wd = 0);
    @(negedge clk);
    ev_ce[ch] = ce; ev_ue[ch] = ue;
    ev_rank[ch*2 +: 2] = rank; ev_bank[ch*3 +: 3] = bank;
    ev_row[ch*16 +: 16] = row; ev_col[ch*16 +: 16] = col; ev_synd[ch*8 +: 8] = synd;
    reg_wr = wr; reg_addr = 0; reg_wdata = {30'd0, wd};
    @(negedge clk);
    ev_ce = 0; ev_ue = 0; reg_wr = 0;
  endtask

  task automatic wstat(input logic [1:0] wd);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = {30'd0, wd};
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] v;
    rd(0, d); chk("R12 status", d, 0);
    chk("R12 irq", err_irq, 0);
    rd_log(0, v); chk("R12 log0", v, 0);
    rd_log(1, v); chk("R12 log1", v, 0);
  endtask

  task automatic t_ce_first;
    logic [31:0] d; logic [63:0] v;
    post(0, 1, 0, 2, 5, 16'h1234, 16'hABCD, 8'h5A);
    rd(0, d); chk("R1 ce status", d, 1);
    chk("R10 irq set", err_irq, 1);
    rd_log(0, v); chk("R3 layout", v, rec(16'hABCD, 16'h1234, 5, 2, 8'h5A, 2'b01));
    rd(1, d); chk("R11 ch0 rank", d[2:0], 2);
    post(0, 1, 0, 1, 3, 16'h0F0F, 16'h7777, 8'h11);
    rd_log(0, v); chk("R6 first ce kept", v, rec(16'hABCD, 16'h1234, 5, 2, 8'h5A, 2'b01));
  endtask

  task automatic t_ue_replace;
    logic [31:0] d; logic [63:0] v;
    post(0, 0, 1, 3, 6, 16'h2222, 16'h3333, 8'hC3);
    rd(0, d); chk("R4 status both", d, 3);
    rd_log(0, v); chk("R4 ue replaces", v, rec(16'h3333, 16'h2222, 6, 3, 8'hC3, 2'b10));
    post(0, 0, 1, 0, 1, 16'h4444, 16'h5555, 8'h01);
    post(0, 1, 0, 1, 2, 16'h6666, 16'h7777, 8'h02);
    rd_log(0, v); chk("R5 ue frozen", v, rec(16'h3333, 16'h2222, 6, 3, 8'hC3, 2'b10));
  endtask

  task automatic t_w1c;
    logic [31:0] d; logic [63:0] v;
    wstat(2'b00); rd(0, d); chk("R2 write zero keeps", d, 3);
    wstat(2'b01); rd(0, d); chk("R2 clear bit0", d, 2);
    rd_log(0, v); chk("R8 partial clear keeps flags", v[1:0], 2'b10);
    wstat(2'b10); rd(0, d); chk("R2 clear bit1", d, 0);
    chk("R10 irq low", err_irq, 0);
    rd_log(0, v); chk("R8 flags cleared", v, rec(16'h3333, 16'h2222, 6, 3, 8'hC3, 2'b00));
  endtask

  task automatic t_chan1;
    logic [31:0] d; logic [63:0] v;
    post(1, 1, 0, 3, 4, 16'h0101, 16'h0202, 8'h33);
    rd(0, d); chk("R1 ch1 ce", d, 1);
    rd_log(1, v); chk("R3 ch1 log", v, rec(16'h0202, 16'h0101, 4, 3, 8'h33, 2'b01));
    rd(1, d); chk("R11 ch1 rank", d[6:4], 7);
    wstat(2'b11);
    single_chan = 1;
    post(1, 0, 1, 1, 1, 16'h9999, 16'h8888, 8'h44);
    rd(0, d); chk("R7 ch1 ignored status", d, 0);
    rd_log(1, v); chk("R7 ch1 ignored log", v, rec(16'h0202, 16'h0101, 4, 3, 8'h33, 2'b00));
    single_chan = 0;
  endtask

  task automatic t_both_same_cycle;
    logic [31:0] d; logic [63:0] v;
    post(0, 1, 1, 1, 7, 16'hAAAA, 16'hBBBB, 8'h77);
    rd(0, d); chk("R9 both status", d, 3);
    rd_log(0, v); chk("R9 ue wins", v, rec(16'hBBBB, 16'hAAAA, 7, 1, 8'h77, 2'b10));
    wstat(2'b11);
  endtask

  task automatic t_race;
    logic [31:0] d; logic [63:0] v;
    post(0, 1, 0, 2, 2, 16'h1111, 16'h2222, 8'h99, 1'b1, 2'b11);
    rd(0, d); chk("R2 event beats clear", d, 1);
    rd_log(0, v); chk("R2 event logged", v, rec(16'h2222, 16'h1111, 2, 2, 8'h99, 2'b01));
  endtask

  initial begin
    fork
      begin
        #10; @(negedge clk); rst_n = 1;
        t_reset(); t_ce_first(); t_ue_replace(); t_w1c();
        t_chan1(); t_both_same_cycle(); t_race();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule